// File: doc/BRIEF.md
# Nested-Priority Interrupt Controller

This block collects interrupt requests for vector numbers 2 to 45 and drives one interrupt line toward a processor core. Each source has a 2-bit priority level that software can program. A one-cycle pulse on a source's request input marks that source as pending. The controller chooses the best eligible pending source and raises its interrupt output. It also presents the vector number of that source. When the core enters the handler, it pulses an acknowledge input. The controller then drops the presented source's pending flag and latches a 2-bit nesting threshold that matches the source's priority.

The threshold is the lowest priority allowed to interrupt the running handler. It changes in only two ways. An acknowledge sets it from the entered source's priority. A restore pulse loads a code that the core supplies when it returns from a nested handler. A small register port lets software do the following:
- program the priorities;
- read the pending flags, which are active-low;
- read the interrupt state, the threshold and the presented vector;
- set a global disable bit.

A three-state machine sequences the output:
- **IDLE**: nothing is offered. It moves to **OFFER** when an eligible source exists.
- **OFFER**: the interrupt output is high and the vector follows the current winner. It moves to **ENTER** on an acknowledge. It moves back to IDLE when no eligible source is left.
- **ENTER**: this state lasts one cycle and holds the output low while the new threshold takes effect. It then moves to OFFER or to IDLE, depending on eligibility.

Top module: `nic_top`

## Requirements
- R1: A request pulse on bit v-2 of `irq_req_i` marks vector v pending from the next cycle on. The pending words read active-low: 0 means pending and 1 means idle. Address 6 holds vectors 2–17 in bits 0–15. Address 7 holds vectors 18–32 in bits 0–14, with bit 15 reading 1. Address 8 holds vectors 33–45 in bits 0–12, with bits 15–13 reading 1.
- R2: Priority words sit at addresses 0–5. Vector v uses word (v-2)/8, bits 2*((v-2)%8)+1 : 2*((v-2)%8). All priorities reset to 0 and read back as written.
- R3: A pending source is eligible only when two conditions hold: its priority is at least the numeric value of the threshold code, and the disable bit is clear.
- R4: Among eligible sources, the highest priority wins and a tie goes to the lowest vector. `int_o` rises one cycle after an eligible source appears, and `vector_o` shows the winner.
- R5: An acknowledge while `int_o` is high does three things. It clears the pending flag of the vector on `vector_o`. It drops `int_o` for at least the next cycle. It latches a threshold of 01 for priority 0, 10 for priority 1, and 11 for priority 2 or 3.
- R6: An acknowledge while `int_o` is low changes neither the threshold nor any pending flag.
- R7: A restore pulse loads `restore_code_i` into the threshold in the next cycle. If a taken acknowledge falls in the same cycle, the acknowledge's code wins.
- R8: When a request pulse and a taken acknowledge hit the same vector in the same cycle, that vector stays pending.
- R9: The disable bit is bit 5 of the control word at address 9. While it is set, `int_o` falls within two cycles, and pending flags are kept.
- R10: The control word reads as follows: bit 15 = `int_o`, bits 14–13 = threshold, bits 11–6 = `vector_o`, bit 5 = disable, and all other bits 0.
- R11: After reset, no source is pending, `int_o` is 0, the threshold is 00, `vector_o` is 0 and every pending word reads all ones.
- R12: While a handler runs, a request whose priority meets the latched threshold raises `int_o` again and presents its vector. This lets it nest.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_req_i | input | 44 | Per-source request pulses; bit i is vector i+2 |
| ack_i | input | 1 | Core entered the handler of the presented vector |
| restore_i | input | 1 | Reload threshold on return from a nested handler |
| restore_code_i | input | 2 | Threshold code to reload |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register word address |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Register read data (combinational) |
| int_o | output | 1 | Interrupt request toward the core |
| vector_o | output | 6 | Presented vector number |
| thresh_o | output | 2 | Current nesting threshold code |

## Verification
Two pairs of functions can land on the same clock edge. The first pair is an acknowledge and a restore. The second pair is an acknowledge and a new request for the vector being cleared. The bench drives each pair deliberately in one cycle. It then judges the threshold output, the pending readback and the re-raised interrupt against a behavioural model. That model applies the same-cycle precedence rules independently of the design's structure.

// File: rtl/nic_pkg.sv
package nic_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_OFFER = 2'd1,
        ST_ENTER = 2'd2
    } nic_state_e;

    typedef logic [1:0] prio_t;

    // Threshold code latched on handler entry for a given priority
    function automatic logic [1:0] entry_code(input prio_t p);
        logic [1:0] c;
        unique case (p)
            2'd0:    c = 2'b01;
            2'd1:    c = 2'b10;
            default: c = 2'b11;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/nic_pend_store.sv
module nic_pend_store #(
    parameter int NUM_SRC = 44,
    parameter int IDX_W   = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] set_i,
    input  logic               clr_en_i,
    input  logic [IDX_W-1:0]   clr_idx_i,
    output logic [NUM_SRC-1:0] pend_o
);

    logic [NUM_SRC-1:0] flag_q;

    generate
        for (genvar i = 0; i < NUM_SRC; i++) begin : g_flag
            logic hit_clr;
            assign hit_clr = clr_en_i && (clr_idx_i == IDX_W'(i));

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    flag_q[i] <= 1'b0;
                end else if (set_i[i]) begin
                    flag_q[i] <= 1'b1;   // new request outranks a same-cycle clear
                end else if (hit_clr) begin
                    flag_q[i] <= 1'b0;
                end
            end
        end
    endgenerate

    assign pend_o = flag_q;

endmodule

// File: rtl/nic_arbiter.sv
module nic_arbiter #(
    parameter int NUM_SRC = 44,
    parameter int IDX_W   = 6
) (
    input  logic [NUM_SRC-1:0]   pend_i,
    input  logic [2*NUM_SRC-1:0] prio_i,
    input  logic [1:0]           thresh_i,
    input  logic                 dis_i,
    output logic                 any_o,
    output logic [IDX_W-1:0]     win_idx_o,
    output logic [1:0]           win_prio_o
);

    always_comb begin
        logic [1:0] p;
        logic       found;
        logic [1:0] best_p;
        logic [IDX_W-1:0] best_i;
        found  = 1'b0;
        best_p = 2'd0;
        best_i = '0;
        // Scan downward; ">=" lets a lower index take a priority tie
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            p = prio_i[2*i +: 2];
            if (pend_i[i] && !dis_i && (p >= thresh_i)) begin
                if (!found || (p >= best_p)) begin
                    found  = 1'b1;
                    best_p = p;
                    best_i = IDX_W'(i);
                end
            end
        end
        any_o      = found;
        win_idx_o  = best_i;
        win_prio_o = best_p;
    end

endmodule

// File: rtl/nic_regs.sv
module nic_regs #(
    parameter int NUM_SRC  = 44,
    parameter int TOP_BASE = 31,
    parameter int ADDR_W   = 4,
    parameter int VEC_W    = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_i,
    input  logic [ADDR_W-1:0]    addr_i,
    input  logic [15:0]          wdata_i,
    input  logic [NUM_SRC-1:0]   pend_i,
    input  logic                 int_i,
    input  logic [1:0]           thresh_i,
    input  logic [VEC_W-1:0]     vec_i,
    output logic [2*NUM_SRC-1:0] prio_o,
    output logic                 dis_o,
    output logic [15:0]          rdata_o
);

    localparam int PRIO_WORDS = (NUM_SRC + 7) / 8;
    localparam int LOW_WORDS  = (TOP_BASE + 15) / 16;
    localparam int PEND_BASE  = PRIO_WORDS;
    localparam int PEND_WORDS = LOW_WORDS + 1;
    localparam int CTRL_ADDR  = PEND_BASE + PEND_WORDS;
    localparam int DIS_BIT    = 5;
    localparam int VEC_LSB    = 6;

    logic [15:0] prio_q [PRIO_WORDS];
    logic        dis_q;
    logic [15:0] pend_word [PEND_WORDS];
    int          a;

    assign a = int'(addr_i);

    generate
        for (genvar w = 0; w < PRIO_WORDS; w++) begin : g_prio_word
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    prio_q[w] <= '0;
                end else if (wr_i && (a == w)) begin
                    prio_q[w] <= wdata_i;
                end
            end
        end
        for (genvar i = 0; i < NUM_SRC; i++) begin : g_prio_map
            assign prio_o[2*i +: 2] = prio_q[i/8][2*(i%8) +: 2];
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dis_q <= 1'b0;
        end else if (wr_i && (a == CTRL_ADDR)) begin
            dis_q <= wdata_i[DIS_BIT];
        end
    end

    assign dis_o = dis_q;

    // Active-low pending view; absent slots read as "no request"
    always_comb begin
        for (int k = 0; k < PEND_WORDS; k++) begin
            for (int b = 0; b < 16; b++) begin
                int idx;
                int lim;
                idx = (k < LOW_WORDS) ? (16 * k + b) : (TOP_BASE + b);
                lim = (k < LOW_WORDS) ? TOP_BASE : NUM_SRC;
                if (idx < lim) begin
                    pend_word[k][b] = ~pend_i[idx];
                end else begin
                    pend_word[k][b] = 1'b1;
                end
            end
        end
    end

    always_comb begin
        rdata_o = '0;
        if (a < PRIO_WORDS) begin
            rdata_o = prio_q[a];
        end else if (a < CTRL_ADDR) begin
            rdata_o = pend_word[a - PEND_BASE];
        end else if (a == CTRL_ADDR) begin
            rdata_o[15]              = int_i;
            rdata_o[14:13]           = thresh_i;
            rdata_o[VEC_LSB +: VEC_W] = vec_i;
            rdata_o[DIS_BIT]         = dis_q;
        end
    end

endmodule

// File: rtl/nic_top.sv
module nic_top
    import nic_pkg::*;
#(
    parameter int VEC_FIRST = 2,
    parameter int VEC_LAST  = 45,
    parameter int TOP_FIRST = 33,
    parameter int ADDR_W    = 4
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic [VEC_LAST-VEC_FIRST:0]        irq_req_i,
    input  logic                               ack_i,
    input  logic                               restore_i,
    input  logic [1:0]                         restore_code_i,
    input  logic                               reg_wr_i,
    input  logic [ADDR_W-1:0]                  reg_addr_i,
    input  logic [15:0]                        reg_wdata_i,
    output logic [15:0]                        reg_rdata_o,
    output logic                               int_o,
    output logic [$clog2(VEC_LAST+1)-1:0]      vector_o,
    output logic [1:0]                         thresh_o
);

    localparam int NUM_SRC   = VEC_LAST - VEC_FIRST + 1;
    localparam int IDX_W     = $clog2(NUM_SRC);
    localparam int VEC_W     = $clog2(VEC_LAST + 1);
    localparam int TOP_BASE  = TOP_FIRST - VEC_FIRST;
    localparam int CTRL_ADDR = (NUM_SRC + 7) / 8 + (TOP_BASE + 15) / 16 + 1;

    nic_state_e         state_q, state_d;
    logic [NUM_SRC-1:0] pend;
    logic [2*NUM_SRC-1:0] prio_flat;
    logic               dis;
    logic               any_elig;
    logic [IDX_W-1:0]   win_idx;
    prio_t              win_prio;
    logic [IDX_W-1:0]   idx_q;
    prio_t              pprio_q;
    logic [VEC_W-1:0]   vec_q;
    logic [1:0]         thresh_q;
    logic               take_ack;

    assign take_ack = (state_q == ST_OFFER) && ack_i;

    nic_pend_store #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_pend (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_i     (irq_req_i),
        .clr_en_i  (take_ack),
        .clr_idx_i (idx_q),
        .pend_o    (pend)
    );

    nic_arbiter #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_arb (
        .pend_i     (pend),
        .prio_i     (prio_flat),
        .thresh_i   (thresh_q),
        .dis_i      (dis),
        .any_o      (any_elig),
        .win_idx_o  (win_idx),
        .win_prio_o (win_prio)
    );

    nic_regs #(
        .NUM_SRC (NUM_SRC),
        .TOP_BASE(TOP_BASE),
        .ADDR_W  (ADDR_W),
        .VEC_W   (VEC_W)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_i     (reg_wr_i),
        .addr_i   (reg_addr_i),
        .wdata_i  (reg_wdata_i),
        .pend_i   (pend),
        .int_i    (int_o),
        .thresh_i (thresh_q),
        .vec_i    (vec_q),
        .prio_o   (prio_flat),
        .dis_o    (dis),
        .rdata_o  (reg_rdata_o)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  state_d = any_elig ? ST_OFFER : ST_IDLE;
            ST_OFFER: begin
                if (ack_i)          state_d = ST_ENTER;
                else if (!any_elig) state_d = ST_IDLE;
                else                state_d = ST_OFFER;
            end
            ST_ENTER: state_d = any_elig ? ST_OFFER : ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Output registers: presented vector and nesting threshold
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vec_q    <= '0;
            idx_q    <= '0;
            pprio_q  <= '0;
            thresh_q <= 2'b00;
        end else begin
            if (state_d == ST_OFFER) begin
                vec_q   <= VEC_W'(win_idx) + VEC_W'(VEC_FIRST);
                idx_q   <= win_idx;
                pprio_q <= win_prio;
            end
            if (take_ack)       thresh_q <= entry_code(pprio_q);
            else if (restore_i) thresh_q <= restore_code_i;
        end
    end

    assign int_o    = (state_q == ST_OFFER);
    assign vector_o = vec_q;
    assign thresh_o = thresh_q;

endmodule

// File: rtl/nic_checker.sv
module nic_checker #(
    parameter int VEC_FIRST = 2,
    parameter int VEC_LAST  = 45,
    parameter int VEC_W     = 6,
    parameter int ADDR_W    = 4,
    parameter int CTRL_ADDR = 9
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ack_i,
    input logic              restore_i,
    input logic [1:0]        restore_code_i,
    input logic              reg_wr_i,
    input logic [ADDR_W-1:0] reg_addr_i,
    input logic [15:0]       reg_wdata_i,
    input logic              int_o,
    input logic [VEC_W-1:0]  vector_o,
    input logic [1:0]        thresh_o
);

    // R5: a taken acknowledge drops the interrupt in the next cycle
    a_r5_ack_drops_int: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && int_o) |=> !int_o);

    // R6: without a taken acknowledge or a restore, the threshold holds
    a_r6_thresh_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!restore_i && !(ack_i && int_o)) |=> $stable(thresh_o));

    // R7: a lone restore loads the supplied code
    a_r7_restore_loads: assert property (@(posedge clk) disable iff (!rst_n)
        (restore_i && !(ack_i && int_o)) |=> (thresh_o == $past(restore_code_i)));

    // R4: an asserted interrupt always presents a vector in range
    a_r4_vector_range: assert property (@(posedge clk) disable iff (!rst_n)
        int_o |-> ((int'(vector_o) >= VEC_FIRST) && (int'(vector_o) <= VEC_LAST)));

    // R9: setting the disable bit removes the interrupt within two cycles
    a_r9_disable_quiets: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_i && (int'(reg_addr_i) == CTRL_ADDR) && reg_wdata_i[5]) |=> ##1 !int_o);

endmodule

bind nic_top nic_checker #(
    .VEC_FIRST(VEC_FIRST),
    .VEC_LAST (VEC_LAST),
    .VEC_W    (VEC_W),
    .ADDR_W   (ADDR_W),
    .CTRL_ADDR(CTRL_ADDR)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .ack_i          (ack_i),
    .restore_i      (restore_i),
    .restore_code_i (restore_code_i),
    .reg_wr_i       (reg_wr_i),
    .reg_addr_i     (reg_addr_i),
    .reg_wdata_i    (reg_wdata_i),
    .int_o          (int_o),
    .vector_o       (vector_o),
    .thresh_o       (thresh_o)
);

// File: tb/tb_nic_top.sv
module tb_nic_top;

    localparam int NS = 44;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NS-1:0] irq_req = '0;
    logic          ack = 1'b0;
    logic          restore = 1'b0;
    logic [1:0]    restore_code = 2'b00;
    logic          reg_wr = 1'b0;
    logic [3:0]    reg_addr = '0;
    logic [15:0]   reg_wdata = '0;
    logic [15:0]   reg_rdata;
    logic          int_o;
    logic [5:0]    vector_o;
    logic [1:0]    thresh_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    nic_top dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .irq_req_i      (irq_req),
        .ack_i          (ack),
        .restore_i      (restore),
        .restore_code_i (restore_code),
        .reg_wr_i       (reg_wr),
        .reg_addr_i     (reg_addr),
        .reg_wdata_i    (reg_wdata),
        .reg_rdata_o    (reg_rdata),
        .int_o          (int_o),
        .vector_o       (vector_o),
        .thresh_o       (thresh_o)
    );

    // ---------------- behavioural reference model ----------------
    bit m_pend [NS];
    int m_prio [NS];
    int m_thr, m_st, m_vec, m_pp;
    bit m_dis;

    function automatic int code_of(int p);
        return (p == 0) ? 1 : (p == 1) ? 2 : 3;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            foreach (m_pend[i]) begin m_pend[i] = 0; m_prio[i] = 0; end
            m_thr = 0; m_st = 0; m_vec = 0; m_pp = 0; m_dis = 0;
        end else begin
            int  win, bp, nxt;
            bit  took;
            win = -1; bp = -1;
            for (int i = 0; i < NS; i++)
                if (m_pend[i] && !m_dis && m_prio[i] >= m_thr && m_prio[i] > bp) begin
                    win = i; bp = m_prio[i];
                end
            took = (m_st == 1) && ack;
            if (m_st == 1) nxt = ack ? 2 : (win >= 0 ? 1 : 0);
            else           nxt = (win >= 0) ? 1 : 0;
            if (took)         m_thr = code_of(m_pp);
            else if (restore) m_thr = restore_code;
            if (took) m_pend[m_vec - 2] = 0;
            for (int i = 0; i < NS; i++) if (irq_req[i]) m_pend[i] = 1;
            if (nxt == 1) begin m_vec = win + 2; m_pp = bp; end
            if (reg_wr && reg_addr < 6)
                for (int s = 0; s < 8; s++)
                    if (reg_addr * 8 + s < NS) m_prio[reg_addr * 8 + s] = (reg_wdata >> (2 * s)) & 3;
            if (reg_wr && reg_addr == 9) m_dis = reg_wdata[5];
            m_st = nxt;
        end
    end

    task automatic chk(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // every-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(int_o == (m_st == 1), "R4 int vs model", int_o, m_st == 1);
            chk(thresh_o == 2'(m_thr), "R5 thresh vs model", thresh_o, m_thr);
            chk(vector_o == 6'(m_vec), "R4 vector vs model", vector_o, m_vec);
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(int a, int d);
        @(negedge clk); reg_wr = 1; reg_addr = 4'(a); reg_wdata = 16'(d);
        @(negedge clk); reg_wr = 0;
    endtask

    task automatic rdchk(int a, int exp, string req);
        reg_addr = 4'(a);
        #1;
        chk(reg_rdata == 16'(exp), req, reg_rdata, exp);
    endtask

    task automatic pulse(int v);
        @(negedge clk); irq_req[v - 2] = 1;
        @(negedge clk); irq_req = '0;
    endtask

    task automatic do_ack();
        @(negedge clk); ack = 1;
        @(negedge clk); ack = 0;
    endtask

    task automatic do_restore(int c);
        @(negedge clk); restore = 1; restore_code = 2'(c);
        @(negedge clk); restore = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        step(3);
        rst_n = 1;
        step(1);
        // R11 reset state
        chk(int_o == 0, "R11 int after reset", int_o, 0);
        chk(thresh_o == 0, "R11 thresh after reset", thresh_o, 0);
        chk(vector_o == 0, "R11 vector after reset", vector_o, 0);
        rdchk(6, 16'hFFFF, "R11 pending word 6");
        rdchk(7, 16'hFFFF, "R11 pending word 7");
        rdchk(8, 16'hFFFF, "R11 pending word 8");
        rdchk(9, 16'h0000, "R11 control word");

        // R2 priorities: v5=1, v9=1, v20=2, v40=3, v3=0
        wr(0, 16'h4040);
        wr(2, 16'h0020);
        wr(4, 16'h3000);
        rdchk(0, 16'h4040, "R2 priority word 0");
        rdchk(4, 16'h3000, "R2 priority word 4");

        // R1 + R4 tie: v5 and v9 at priority 1 together
        @(negedge clk); irq_req[3] = 1; irq_req[7] = 1;
        @(negedge clk); irq_req = '0;
        rdchk(6, 16'hFF77, "R1 active-low pending");
        step(2);
        chk(int_o == 1, "R4 int raised", int_o, 1);
        chk(vector_o == 5, "R4 tie to lowest vector", vector_o, 5);
        rdchk(9, 16'h8140, "R10 control layout");

        // R5 acknowledge
        do_ack();
        chk(int_o == 0, "R5 int dropped", int_o, 0);
        chk(thresh_o == 2'b10, "R5 code for priority 1", thresh_o, 2);
        rdchk(6, 16'hFF7F, "R5 pending cleared");
        step(3);
        chk(int_o == 0, "R3 equal priority blocked", int_o, 0);

        // R3 lower priority blocked, R12 nesting by higher priority
        pulse(3);
        step(3);
        chk(int_o == 0, "R3 lower priority blocked", int_o, 0);
        pulse(20);
        rdchk(7, 16'hFFFB, "R1 pending word 7");
        step(2);
        chk(int_o == 1 && vector_o == 20, "R12 nested preemption", vector_o, 20);
        do_ack();
        chk(thresh_o == 2'b11, "R5 code for priority 2", thresh_o, 3);
        pulse(40);
        step(2);
        chk(int_o == 1 && vector_o == 40, "R12 priority 3 nests", vector_o, 40);

        // R8 request and acknowledge on the same vector
        @(negedge clk); ack = 1; irq_req[38] = 1;
        @(negedge clk); ack = 0; irq_req = '0;
        chk(int_o == 0, "R8 int drop on entry", int_o, 0);
        rdchk(8, 16'hFF7F, "R8 vector stays pending");
        step(1);
        chk(int_o == 1 && vector_o == 40, "R8 re-raised", vector_o, 40);
        do_ack();
        rdchk(8, 16'hFFFF, "R5 top word cleared");

        // R6 acknowledge with no interrupt
        step(2);
        do_ack();
        chk(thresh_o == 2'b11, "R6 ignored ack keeps thresh", thresh_o, 3);
        rdchk(6, 16'hFF7D, "R6 ignored ack keeps pending");

        // R7 restore, then restore colliding with acknowledge
        do_restore(1);
        chk(thresh_o == 2'b01, "R7 restore loads", thresh_o, 1);
        step(2);
        chk(int_o == 1 && vector_o == 9, "R7 v9 eligible after restore", vector_o, 9);
        @(negedge clk); ack = 1; restore = 1; restore_code = 2'b00;
        @(negedge clk); ack = 0; restore = 0;
        chk(thresh_o == 2'b10, "R7 ack wins over restore", thresh_o, 2);

        // R9 disable
        do_restore(0);
        step(2);
        chk(int_o == 1 && vector_o == 3, "R3 priority 0 at threshold 00", vector_o, 3);
        wr(9, 16'h0020);
        step(1);
        chk(int_o == 0, "R9 disable drops int", int_o, 0);
        rdchk(6, 16'hFFFD, "R9 pending kept");
        rdchk(9, 16'h00E0, "R10 control with disable");
        wr(9, 16'h0000);
        step(2);
        chk(int_o == 1 && vector_o == 3, "R9 re-enable", vector_o, 3);
        do_ack();
        step(3);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule